// File: doc/BRIEF.md
# Tick Counter with Compare Match

A free-running 64-bit-word tick counter paired with a single compare limit. One bit position of the word, chosen by a parameter, does not count. It acts as a timer-disable flag that is shared by the counter word and the compare word. The counter advances by one every `PRESCALE` clock cycles. When an armed limit is reached and the timer is enabled, the block raises a one-cycle pulse, `softIntSet`. Surrounding logic uses this pulse to set its soft-interrupt bit and to wake the processor.

Software reaches the block through one write port and one read port. `wrSel` = 0 writes the counter word, and `wrSel` = 1 writes the compare word. In both cases the bits outside the flag position become the new count or limit, and the flag bit becomes the new disable state. `rdData` always shows the running count, with the flag bit set while the timer is disabled.

A limit of zero disarms the compare. A nonzero limit that is not above the count fires on the next tick rather than waiting a full wrap. A match fires once and stays disarmed until the compare word is written again.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, `rdData` reads the flag bit (bit 63) set with a zero count, and `softIntSet` is low.
- R2: A counter write loads `wrData` with bit 63 cleared as the count, and sets the disable state to `wrData[63]`. `rdData` returns the count with bit 63 ORed in while disabled.
- R3: The count advances by one each `PRESCALE` cycles. A counter write restarts the prescale phase, so the first advance comes `PRESCALE` cycles after the write.
- R4: The count skips the flag bit and wraps from 2^63-1 to 0.
- R5: A compare write with bit 63 clear and a limit above the count fires `softIntSet` for exactly one cycle, in the cycle in which `rdData` first shows the limit.
- R6: After firing, the compare stays disarmed: the count passing the limit again gives no pulse until the next compare write.
- R7: A compare write whose limit bits are zero arms nothing, and no pulse follows.
- R8: A compare write with bit 63 set disables the timer (`rdData` shows bit 63) and gives no pulse.
- R9: A nonzero limit at or below the count at the end of the write cycle fires at the next tick. `rdData` then shows the written count plus one.
- R10: If the timer is disabled by a counter write while armed, the match passes with no pulse and disarms the compare. Re-enabling the timer afterwards gives no pulse.
- R11: A compare write with bit 63 clear enables a disabled timer (`rdData` bit 63 reads 0), and its limit then fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the selected word |
| wrSel | input | 1 | 0 selects the counter word, 1 selects the compare word |
| wrData | input | 64 | Write data; bit 63 carries the disable flag |
| rdData | output | 64 | Running count, with bit 63 set while disabled |
| softIntSet | output | 1 | One-cycle pulse on a compare match |

## Verification
The compare path is exercised with three kinds of limit. The first is a limit ahead of the count, which must fire exactly when the count reaches it. The second is a limit at or behind the count, which must fire one tick later instead of waiting a wrap. The third is a zero limit, which must stay silent. Disable is applied through each of the two words, one sequence re-enables after the match has passed, and a second sweep past a spent limit distinguishes one-shot behaviour from re-arming. Readbacks across a count write, the prescale boundary and the 2^63 wrap pin down when the count advances and how the flag bit is merged.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;
  // Strobes from the control unit to the count/limit datapath
  typedef struct packed {
    logic loadCnt;
    logic loadLim;
    logic advance;
  } dpCmd_t;
endpackage

// File: rtl/tick_dp.sv
module tick_dp
  import tick_cmp_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int DIS_BIT = 63
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] wrData,
  input  logic             disabled,
  output logic [CNT_W-1:0] rdData,
  output logic             incHitsLim,
  output logic             wrLimPast,
  output logic             wrLimZero
);
  localparam logic [CNT_W-1:0] FLAG = {{(CNT_W-1){1'b0}}, 1'b1} << DIS_BIT;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cntInc;
  logic [CNT_W-1:0] cntAfter;
  logic [CNT_W-1:0] wrVal;

  // Forcing the flag bit high lets the carry jump over it
  assign cntInc     = ((count | FLAG) + 1'b1) & ~FLAG;
  assign cntAfter   = cmd.advance ? cntInc : count;
  assign wrVal      = wrData & ~FLAG;
  assign wrLimPast  = (wrVal <= cntAfter);
  assign wrLimZero  = (wrVal == '0);
  assign incHitsLim = (cntInc == limit);
  assign rdData     = count | (disabled ? FLAG : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      limit <= '0;
    end else begin
      if (cmd.loadCnt)      count <= wrVal;
      else if (cmd.advance) count <= cntInc;
      if (cmd.loadLim)      limit <= wrVal;
    end
  end

  // R4
  count_flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !count[DIS_BIT]);
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.loadCnt && !cmd.advance) |=> $stable(count));
  // R6
  limit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.loadLim |=> $stable(limit));
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_cmp_pkg::*;
#(
  parameter int PRESCALE = 1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrEn,
  input  logic   wrSel,
  input  logic   wrDis,
  input  logic   incHitsLim,
  input  logic   wrLimPast,
  input  logic   wrLimZero,
  output dpCmd_t cmd,
  output logic   disabled,
  output logic   hitPulse
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] preCnt;
  logic armed;
  logic late;
  logic wrCnt;
  logic wrLim;
  logic phaseEnd;
  logic advance;
  logic matchNow;

  assign wrCnt    = wrEn && !wrSel;
  assign wrLim    = wrEn && wrSel;
  assign phaseEnd = (preCnt == LAST);
  assign advance  = phaseEnd && !wrCnt;
  assign matchNow = advance && armed && !wrLim && (late || incHitsLim);

  always_comb begin
    cmd.loadCnt = wrCnt;
    cmd.loadLim = wrLim;
    cmd.advance = advance;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      disabled <= 1'b1;
      armed    <= 1'b0;
      late     <= 1'b0;
      hitPulse <= 1'b0;
    end else begin
      if (wrCnt || phaseEnd) preCnt <= '0;
      else                   preCnt <= preCnt + 1'b1;
      if (wrEn) disabled <= wrDis;
      if (wrLim) begin
        armed <= !wrDis && !wrLimZero;
        late  <= wrLimPast;
      end else if (matchNow) begin
        armed <= 1'b0;
        late  <= 1'b0;
      end
      hitPulse <= matchNow && !disabled;
    end
  end

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitPulse |=> !hitPulse);
  // R8
  pulse_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitPulse |-> !$past(disabled));
  // R7
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrLim && wrLimZero) |=> !armed);

  generate
    if (PRESCALE > 1) begin : g_gap
      // R3
      advance_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        cmd.advance |=> !cmd.advance);
    end
  endgenerate
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tick_cmp_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int DIS_BIT  = 63,
  parameter int PRESCALE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             softIntSet
);
  dpCmd_t cmd;
  logic disabled;
  logic incHitsLim;
  logic wrLimPast;
  logic wrLimZero;

  tick_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrDis(wrData[DIS_BIT]), .incHitsLim(incHitsLim),
    .wrLimPast(wrLimPast), .wrLimZero(wrLimZero),
    .cmd(cmd), .disabled(disabled), .hitPulse(softIntSet)
  );

  tick_dp #(.CNT_W(CNT_W), .DIS_BIT(DIS_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData),
    .disabled(disabled), .rdData(rdData), .incHitsLim(incHitsLim),
    .wrLimPast(wrLimPast), .wrLimZero(wrLimZero)
  );
endmodule

// File: tb/sim_tick_cmp_timer.sv
module sim_tick_cmp_timer;
  localparam logic [63:0] FLAG = 64'h8000_0000_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic softIntSet;

  int nChecks = 0;
  int nFails = 0;
  int strays = 0;
  logic [63:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  tick_cmp_timer #(.PRESCALE(3)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdData(rdData), .softIntSet(softIntSet)
  );

  // Monitor: every pulse pops one expected readback value
  always @(negedge clk) begin
    if (rstN && softIntSet) begin
      if (expQ.size() == 0) begin
        strays++;
      end else begin
        logic [63:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        nChecks++;
        if (rdData !== e) begin
          nFails++;
          $display("FAIL %s: readback at pulse %h expected %h", t, rdData, e);
        end
      end
    end
  end

  task automatic wrWord(input logic sel, input logic [63:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = v;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkRead(input logic [63:0] e, input string t);
    nChecks++;
    if (rdData !== e) begin
      nFails++;
      $display("FAIL %s: rdData %h expected %h", t, rdData, e);
    end
  endtask

  task automatic expectHit(input logic [63:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
  endtask

  task automatic checkpoint(input string t);
    nChecks++;
    if (expQ.size() != 0 || strays != 0) begin
      nFails++;
      $display("FAIL %s: missing pulses %0d stray pulses %0d expected 0 and 0",
               t, expQ.size(), strays);
    end
    expQ.delete();
    tagQ.delete();
    strays = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    checkRead(FLAG, "R1");
    nChecks++;
    if (softIntSet !== 1'b0) begin
      nFails++;
      $display("FAIL R1: softIntSet %b expected 0", softIntSet);
    end
    rstN = 1'b1;

    // R2: flag merge on readback
    wrWord(1'b0, FLAG | 64'd123);
    checkRead(FLAG | 64'd123, "R2 disabled");
    wrWord(1'b0, 64'd77);
    checkRead(64'd77, "R2 enabled");

    // R3: prescale timing after a count write
    wrWord(1'b0, 64'd10);
    checkRead(64'd10, "R3 load");
    idle(2);
    checkRead(64'd10, "R3 hold");
    idle(1);
    checkRead(64'd11, "R3 first advance");
    idle(3);
    checkRead(64'd12, "R3 second advance");

    // R4: wrap past the flag bit
    wrWord(1'b0, 64'h7FFF_FFFF_FFFF_FFFF);
    checkRead(64'h7FFF_FFFF_FFFF_FFFF, "R4 top");
    idle(3);
    checkRead(64'd0, "R4 wrap");
    checkpoint("R4 quiet");

    // R5: limit ahead of count
    wrWord(1'b0, 64'd0);
    expectHit(64'd4, "R5");
    wrWord(1'b1, 64'd4);
    idle(20);
    checkpoint("R5 pulse");

    // R6: spent limit does not fire again
    wrWord(1'b0, 64'd0);
    expectHit(64'd5, "R6 first");
    wrWord(1'b1, 64'd5);
    idle(21);
    checkpoint("R6 first");
    wrWord(1'b0, 64'd0);
    idle(25);
    checkpoint("R6 no repeat");

    // R7: zero limit
    wrWord(1'b0, 64'd0);
    wrWord(1'b1, 64'd0);
    idle(30);
    checkpoint("R7 zero limit");

    // R8: compare write with flag set
    wrWord(1'b0, 64'd0);
    wrWord(1'b1, FLAG | 64'd4);
    checkRead(FLAG, "R8 readback");
    idle(20);
    checkpoint("R8 silent");

    // R9: limit behind count fires next tick
    wrWord(1'b0, 64'd50);
    expectHit(64'd51, "R9");
    wrWord(1'b1, 64'd20);
    idle(10);
    checkpoint("R9 late pulse");

    // R10: disabled through the counter word while armed
    wrWord(1'b0, 64'd0);
    wrWord(1'b1, 64'd6);
    wrWord(1'b0, FLAG | 64'd1);
    checkRead(FLAG | 64'd1, "R10 disabled");
    idle(30);
    checkpoint("R10 no pulse while disabled");
    wrWord(1'b0, 64'd0);
    idle(30);
    checkpoint("R10 no pulse after re-enable");

    // R11: compare write enables the timer
    wrWord(1'b0, FLAG | 64'd2);
    checkRead(FLAG | 64'd2, "R11 disabled");
    expectHit(64'd8, "R11");
    wrWord(1'b1, 64'd8);
    checkRead(64'd2, "R11 enabled");
    idle(25);
    checkpoint("R11 pulse");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule